// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the 10-bit fetch address of a small accumulator-style processor and works out the next one on every instruction cycle. The decoder around it supplies one-cycle control strobes: jump, call, return, a computed write to the low eight PC bits, hardware and software interrupt entry, and a synchronous restart. The block resolves them by a fixed priority. With no strobe raised, the address advances by one. The 10-bit range covers the whole 1K-word program space, so jumps and calls never need paging.

Return addresses go onto a five-entry ring stack that is 10 bits wide. A call and either kind of interrupt entry push the address of the following instruction, and a return pops one. When software writes the low PC byte, the upper two PC bits come from a separate buffer register, which only an explicit buffer write changes. Jumps, calls, returns and interrupts leave that buffer alone, and the live PC never refreshes it. The block reports stack-full and stack-empty status. A sticky error flag records any push onto a full stack and any pop from an empty one.

Top module: `pc_seq_stack`

## Requirements
- R1: After the asynchronous reset (rst_ni low), and one cycle after restart_i, pc_o is 3FFh, the stack is empty (stk_empty_o=1, stk_full_o=0) and the buffer reads 00h. The asynchronous reset also clears stk_err_o. restart_i leaves stk_err_o unchanged.
- R2: In a cycle with no control strobe, pc_o becomes pc_o+1 modulo 1024, so 3FFh is followed by 000h.
- R3: jmp_i loads pc_o with tgt_i and leaves the buffer unchanged.
- R4: call_i loads pc_o with tgt_i and pushes (pc_o+1) mod 1024. ret_i loads pc_o with the most recently pushed entry that is still stacked. Nested calls return in last-in, first-out order.
- R5: pcl_wr_i loads pc_o with {buffer[1:0], pcl_data_i[7:0]}. A buffer write in the same cycle does not affect that result; the new buffer value applies from the next cycle.
- R6: buf_wr_i stores buf_wdata_i[1:0]. buf_rdata_o is {6'b0, buffer[1:0]}. Jump, call, return, interrupt entry and the low-byte write never change the buffer.
- R7: hw_irq_i loads pc_o with 008h and sw_irq_i loads it with 002h. Each pushes (pc_o+1) mod 1024, just as a call does.
- R8: When several strobes are high, the one that acts is chosen in this order: restart_i, hw_irq_i, sw_irq_i, ret_i, call_i, jmp_i, pcl_wr_i, then sequential advance.
- R9: stk_full_o is high when five entries are stacked and stk_empty_o is high when none are. The two are never high together.
- R10: A push onto a full stack overwrites the oldest entry in ring order. A pop from an empty stack returns the oldest surviving entry and leaves the stack unchanged. Either case sets stk_err_o, which stays high until rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart to the reset vector |
| hw_irq_i | input | 1 | Hardware interrupt entry |
| sw_irq_i | input | 1 | Software interrupt entry |
| ret_i | input | 1 | Return (all return forms) |
| call_i | input | 1 | Subroutine call |
| jmp_i | input | 1 | Jump |
| tgt_i | input | 10 | Jump or call target |
| pcl_wr_i | input | 1 | Computed write of the low PC byte |
| pcl_data_i | input | 8 | Value written to the low PC byte |
| buf_wr_i | input | 1 | Buffer register write |
| buf_wdata_i | input | 2 | Buffer write data |
| buf_rdata_o | output | 8 | Buffer readback, upper six bits zero |
| pc_o | output | 10 | Current fetch address |
| stk_full_o | output | 1 | Five entries stacked |
| stk_empty_o | output | 1 | No entries stacked |
| stk_err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench steps the sequential path through the full 1024-address wrap. A design that truncated the increment or stopped at 3FFh fails that sweep. It sweeps all four buffer values against many low-byte values, and also writes the buffer and the low byte in the same cycle, which catches a design that uses the new buffer value or refreshes the buffer from the live PC. It drives all 128 combinations of the seven strobes and compares the result with a priority model. A swapped priority or a missing push on interrupt entry sends the PC to the wrong address. Overflow and underflow runs check that a sixth push overwrites the oldest slot, that a pop from an empty stack returns the oldest survivor without moving the pointer, and that only rst_ni clears the error flag.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SEL_SEQ, SEL_PCL, SEL_JMP, SEL_CALL, SEL_RET, SEL_SWI, SEL_HWI, SEL_RST
  } pc_sel_e;
endpackage

// File: rtl/pcs_arb.sv
module pcs_arb
  import pcs_pkg::*;
(
  input  logic    restart_i,
  input  logic    hw_irq_i,
  input  logic    sw_irq_i,
  input  logic    ret_i,
  input  logic    call_i,
  input  logic    jmp_i,
  input  logic    pcl_wr_i,
  output pc_sel_e sel_o
);
  always_comb begin
    if      (restart_i) sel_o = SEL_RST;
    else if (hw_irq_i)  sel_o = SEL_HWI;
    else if (sw_irq_i)  sel_o = SEL_SWI;
    else if (ret_i)     sel_o = SEL_RET;
    else if (call_i)    sel_o = SEL_CALL;
    else if (jmp_i)     sel_o = SEL_JMP;
    else if (pcl_wr_i)  sel_o = SEL_PCL;
    else                sel_o = SEL_SEQ;
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] pop_data_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         err_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, wp_inc, wp_dec;
  logic [CW-1:0] cnt;

  assign wp_inc  = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
  assign wp_dec  = (wp == '0) ? PW'(DEPTH - 1) : wp - 1'b1;
  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  // empty pop: slot at wp is the oldest survivor, pointer stays
  assign pop_data_o = empty_o ? mem[wp] : mem[wp_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      wp    <= '0;
      cnt   <= '0;
      err_o <= 1'b0;
    end else if (clr_i) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push_i) begin
      mem[wp] <= push_data_i;
      wp      <= wp_inc;
      if (full_o) err_o <= 1'b1;
      else        cnt   <= cnt + 1'b1;
    end else if (pop_i) begin
      if (empty_o) err_o <= 1'b1;
      else begin
        wp  <= wp_dec;
        cnt <= cnt - 1'b1;
      end
    end
  end

  a_r10_ovf_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clr_i) |=> err_o);
  a_r10_udf_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o && !clr_i) |=> err_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/pcs_hibuf.sv
module pcs_hibuf #(
  parameter int unsigned KEEP_W = 2,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [KEEP_W-1:0] wdata_i,
  output logic [KEEP_W-1:0] hi_o,
  output logic [REG_W-1:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_o <= '0;
    else if (clr_i)  hi_o <= '0;
    else if (wr_i)   hi_o <= wdata_i;
  end

  assign rdata_o = {{(REG_W - KEEP_W){1'b0}}, hi_o};

  a_r6_hold_no_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clr_i) |=> $stable(hi_o));
endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned DEPTH   = 5,
  parameter logic [9:0]  RST_VEC = 10'h3FF,
  parameter logic [9:0]  HWI_VEC = 10'h008,
  parameter logic [9:0]  SWI_VEC = 10'h002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              hw_irq_i,
  input  logic              sw_irq_i,
  input  logic              ret_i,
  input  logic              call_i,
  input  logic              jmp_i,
  input  logic [PC_W-1:0]   tgt_i,
  input  logic              pcl_wr_i,
  input  logic [LO_W-1:0]   pcl_data_i,
  input  logic              buf_wr_i,
  input  logic [PC_W-LO_W-1:0] buf_wdata_i,
  output logic [LO_W-1:0]   buf_rdata_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              stk_full_o,
  output logic              stk_empty_o,
  output logic              stk_err_o
);
  localparam int unsigned HI_W = PC_W - LO_W;

  pc_sel_e         sel;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, pop_data;
  logic [HI_W-1:0] hi_buf;
  logic            push, pop, rst_sel;

  pcs_arb u_arb (
    .restart_i (restart_i), .hw_irq_i (hw_irq_i), .sw_irq_i (sw_irq_i),
    .ret_i     (ret_i),     .call_i   (call_i),   .jmp_i    (jmp_i),
    .pcl_wr_i  (pcl_wr_i),  .sel_o    (sel)
  );

  assign pc_inc  = pc_q + 1'b1;
  assign rst_sel = (sel == SEL_RST);
  assign push    = (sel == SEL_CALL) || (sel == SEL_HWI) || (sel == SEL_SWI);
  assign pop     = (sel == SEL_RET);

  pcs_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (rst_sel),
    .push_i (push), .pop_i (pop), .push_data_i (pc_inc),
    .pop_data_o (pop_data), .full_o (stk_full_o), .empty_o (stk_empty_o),
    .err_o (stk_err_o)
  );

  pcs_hibuf #(.KEEP_W(HI_W), .REG_W(LO_W)) u_hibuf (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (rst_sel), .wr_i (buf_wr_i),
    .wdata_i (buf_wdata_i), .hi_o (hi_buf), .rdata_o (buf_rdata_o)
  );

  always_comb begin
    unique case (sel)
      SEL_RST:  pc_d = PC_W'(RST_VEC);
      SEL_HWI:  pc_d = PC_W'(HWI_VEC);
      SEL_SWI:  pc_d = PC_W'(SWI_VEC);
      SEL_RET:  pc_d = pop_data;
      SEL_CALL: pc_d = tgt_i;
      SEL_JMP:  pc_d = tgt_i;
      SEL_PCL:  pc_d = {hi_buf, pcl_data_i};
      default:  pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC_W'(RST_VEC);
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  a_r1_restart_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pc_o == PC_W'(RST_VEC)) && stk_empty_o);
  a_r7_hw_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_irq_i && !restart_i) |=> (pc_o == PC_W'(HWI_VEC)));
  a_r3_jump_keeps_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_i && !restart_i && !buf_wr_i) |=> $stable(buf_rdata_o));
  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_i || hw_irq_i || sw_irq_i || ret_i || call_i || jmp_i || pcl_wr_i)
    |=> (pc_o == $past(pc_o) + 1'b1));
  a_r4_call_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !restart_i && !hw_irq_i && !sw_irq_i && !ret_i)
    |=> (pc_o == $past(tgt_i)) && !stk_empty_o);
endmodule

// File: tb/test_pc_seq_stack.sv
module test_pc_seq_stack;
  logic       clk = 0, rst_ni = 0;
  logic       restart, hw, sw, ret, call, jmp, pcl_wr, buf_wr;
  logic [9:0] tgt;
  logic [7:0] pcl_data, buf_rdata;
  logic [1:0] buf_wdata;
  logic [9:0] pc;
  logic       full, empty, err;

  int checks = 0, errors = 0;
  logic [9:0] m_pc;
  logic [1:0] m_buf;
  logic [9:0] m_stk [5];
  int m_wp, m_cnt;
  logic m_err;

  always #10 clk = ~clk;

  pc_seq_stack i_pc_seq_stack (
    .clk_i (clk), .rst_ni (rst_ni), .restart_i (restart), .hw_irq_i (hw),
    .sw_irq_i (sw), .ret_i (ret), .call_i (call), .jmp_i (jmp), .tgt_i (tgt),
    .pcl_wr_i (pcl_wr), .pcl_data_i (pcl_data), .buf_wr_i (buf_wr),
    .buf_wdata_i (buf_wdata), .buf_rdata_o (buf_rdata), .pc_o (pc),
    .stk_full_o (full), .stk_empty_o (empty), .stk_err_o (err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "pc", pc, m_pc);
    chk(tag, "buf", buf_rdata, {6'b0, m_buf});
    chk(tag, "full", full, m_cnt == 5);
    chk(tag, "empty", empty, m_cnt == 0);
    chk(tag, "err", err, m_err);
  endtask

  task automatic idle();
    {restart, hw, sw, ret, call, jmp, pcl_wr, buf_wr} = '0;
    tgt = '0; pcl_data = '0; buf_wdata = '0;
  endtask

  task automatic m_push(logic [9:0] v);
    m_stk[m_wp] = v;
    m_wp = (m_wp + 1) % 5;
    if (m_cnt == 5) m_err = 1; else m_cnt++;
  endtask

  function automatic logic [9:0] m_pop();
    if (m_cnt == 0) begin m_err = 1; return m_stk[m_wp]; end
    m_wp = (m_wp + 4) % 5;
    m_cnt--;
    return m_stk[m_wp];
  endfunction

  // R8 priority model: restart, hw, sw, ret, call, jmp, pcl, advance
  task automatic cyc(string tag);
    logic [9:0] nxt;
    nxt = m_pc + 10'd1;
    if (restart) begin m_pc = 10'h3FF; m_cnt = 0; m_wp = 0; m_buf = 0; end
    else if (hw)  begin m_push(nxt); m_pc = 10'h008; end
    else if (sw)  begin m_push(nxt); m_pc = 10'h002; end
    else if (ret) m_pc = m_pop();
    else if (call) begin m_push(nxt); m_pc = tgt; end
    else if (jmp) m_pc = tgt;
    else if (pcl_wr) m_pc = {m_buf, pcl_data};
    else m_pc = nxt;
    if (!restart && buf_wr) m_buf = buf_wdata;
    @(posedge clk);
    @(negedge clk);
    chk_all(tag);
    idle();
  endtask

  task automatic do_reset();
    rst_ni = 0;
    #3;
    m_pc = 10'h3FF; m_buf = 0; m_wp = 0; m_cnt = 0; m_err = 0;
    for (int i = 0; i < 5; i++) m_stk[i] = '0;
    chk_all("R1");
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    @(negedge clk);
    do_reset();

    // R2: sequential advance over the whole space including 3FF->000
    for (int i = 0; i < 1030; i++) cyc("R2");

    // R3 / R6: jumps leave buffer untouched
    buf_wr = 1; buf_wdata = 2'b10; cyc("R6");
    for (int t = 0; t < 1024; t += 37) begin jmp = 1; tgt = 10'(t); cyc("R3"); end

    // R5 / R6: low-byte write sweep against every buffer value
    for (int b = 0; b < 4; b++) begin
      buf_wr = 1; buf_wdata = 2'(b); cyc("R6");
      for (int d = 0; d < 256; d += 17) begin
        pcl_wr = 1; pcl_data = 8'(d); cyc("R5");
      end
    end
    // R5: same-cycle buffer write uses old buffer value
    buf_wr = 1; buf_wdata = 2'b01; cyc("R5");
    pcl_wr = 1; pcl_data = 8'h5A; buf_wr = 1; buf_wdata = 2'b11; cyc("R5");
    pcl_wr = 1; pcl_data = 8'hA5; cyc("R5");

    // R4 / R9: five nested calls then five returns
    for (int k = 0; k < 5; k++) begin call = 1; tgt = 10'(100 * k + 7); cyc("R4"); end
    chk("R9", "full after 5", full, 1);
    for (int k = 0; k < 5; k++) begin ret = 1; cyc("R4"); end
    chk("R9", "empty after 5", empty, 1);

    // R7: interrupt entries push next address
    jmp = 1; tgt = 10'h1F0; cyc("R7");
    hw = 1; cyc("R7");
    sw = 1; cyc("R7");
    ret = 1; cyc("R7");
    ret = 1; cyc("R7");

    // R10: overflow then underflow
    for (int k = 0; k < 7; k++) begin call = 1; tgt = 10'(300 + k); cyc("R10"); end
    for (int k = 0; k < 7; k++) begin ret = 1; cyc("R10"); end
    // R1 / R10: restart empties stack but keeps error
    restart = 1; buf_wr = 1; buf_wdata = 2'b11; cyc("R1");
    chk("R10", "err kept over restart", err, 1);

    // R8: every strobe combination, buffer written alongside
    for (int r = 0; r < 2; r++)
      for (int m = 0; m < 128; m++) begin
        {restart, hw, sw, ret, call, jmp, pcl_wr} = 7'(m);
        tgt = 10'(m * 7 + 3); pcl_data = 8'(m * 5); buf_wr = m[0]; buf_wdata = 2'(m >> 1);
        cyc("R8");
      end

    // R1 / R10: async reset mid-run clears error
    for (int k = 0; k < 6; k++) begin call = 1; tgt = 10'(k); cyc("R10"); end
    do_reset();
    cyc("R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule